// File: doc/BRIEF.md
# Single-Operand Negate/Clear/Complement ALU

This block performs the four one-operand integer operations that a processor datapath uses for two's-complement negation, negation with extend, clearing and bitwise inversion. Each can run on a byte, word or long field of a 32-bit register value. The caller supplies the operation kind, the size code, the full 32-bit register value, and the current extend (X) and zero (Z) condition flags. The block returns the new register value, with only the addressed field changed. It also returns the new N, Z, V, C and X flags and a cycle-count hint for the sequencer. The hint depends on the size and on whether the destination is a register or memory.

Address calculation and bus cycles are handled elsewhere; this block only computes the result. A single register stage holds the outputs. A result appears one clock after the request is presented, and `out_valid` marks it. The size code 3 does not name a size, and the block reports it as illegal instead of computing anything.

Top module: `unary_alu`

## Requirements
- R1: Kind codes are 0 = negate with extend, 1 = clear, 2 = negate, 3 = NOT. Size codes are 0 = byte (bits 7:0), 1 = word (bits 15:0), 2 = long (bits 31:0). For size code 3, `illegal` is 1, the result equals the operand, N, V and C are 0, Z equals `z_in`, X equals `x_in` and the cycle hint is 0. For all other sizes `illegal` is 0.
- R2: Negate with extend produces, in the sized field, 0 minus the field minus `x_in`, modulo 2^width.
- R3: For negate with extend, Z is 1 only when `z_in` is 1 and the sized result is zero. A nonzero result clears Z, and a zero result never sets it.
- R4: Negate produces 0 minus the sized field, modulo 2^width. Z is set exactly when the sized result is zero.
- R5: For negate and negate with extend, C and X both equal the borrow out of the sized subtraction. V is set when the true signed result does not fit in the field width.
- R6: Clear produces a zero field and sets N=0, Z=1, V=0, C=0, with X equal to `x_in`.
- R7: NOT produces the bitwise inverse of the field. Z is set when that inverse is zero. V and C are 0, and X equals `x_in`.
- R8: N equals the top bit of the sized result field: bit 7, 15 or 31.
- R9: Result bits above the addressed field equal the corresponding operand bits.
- R10: The cycle hint is 4 for byte and word, and 6 for long. It is doubled when `dst_mem` is 1.
- R11: All outputs are registered. `out_valid` follows `in_valid` by one clock, and reset clears `out_valid`, the result, the flags and the hint to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op_kind | input | 2 | Operation kind code |
| op_size | input | 2 | Operand size code |
| operand | input | 32 | Full register value holding the field |
| x_in | input | 1 | Current extend flag |
| z_in | input | 1 | Current zero flag |
| dst_mem | input | 1 | Destination is memory (1) or a register (0) |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | New register value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry/borrow flag |
| flag_x | output | 1 | Extend flag |
| illegal | output | 1 | Size code 3 was presented |
| cycles | output | CYC_W | Cycle-count hint |

## Verification
The assertions assume the inputs are known, 2-state values in every cycle where `in_valid` is high. They also assume the operand and flags sampled with that request are the ones the registered outputs answer one clock later. No backpressure is modelled, so there is never a held or repeated request. The stimulus follows these assumptions: it changes inputs only at the falling edge and keeps `in_valid` high through each sweep. It drives every kind and flag combination over the whole byte range, drives word and long operands through sign-boundary corners and a pseudo-random spread, and presents size code 3 only in a dedicated pass that checks the illegal path.

// File: rtl/unary_alu_pkg.sv
package unary_alu_pkg;

  localparam int unsigned DATA_W = 32;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [DATA_W:0]   wide_t;

  typedef enum logic [1:0] {
    KIND_NEGX = 2'd0,
    KIND_CLR  = 2'd1,
    KIND_NEG  = 2'd2,
    KIND_NOT  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic x;
  } flags_t;

  // Mask covering the addressed field for a size code.
  function automatic word_t field_mask(size_e s);
    word_t m;
    case (s)
      SZ_BYTE: m = word_t'(32'h0000_00FF);
      SZ_WORD: m = word_t'(32'h0000_FFFF);
      default: m = '1;
    endcase
    return m;
  endfunction

  // Sign bit of the field for a size code.
  function automatic logic field_sign(word_t v, size_e s);
    logic b;
    case (s)
      SZ_BYTE: b = v[7];
      SZ_WORD: b = v[15];
      default: b = v[DATA_W-1];
    endcase
    return b;
  endfunction

  // Zero minus a minus borrow-in, one bit wider to expose the borrow.
  function automatic wide_t zero_minus(word_t a, logic bin);
    return wide_t'(0) - {1'b0, a} - wide_t'(bin);
  endfunction

endpackage

// File: rtl/unary_alu_size_dec.sv
module unary_alu_size_dec
  import unary_alu_pkg::*;
(
  input  logic [1:0] op_size,
  output size_e      size_o,
  output word_t      mask_o,
  output logic       legal_o
);
  always_comb begin
    size_o  = size_e'(op_size);
    legal_o = (size_o != SZ_BAD);
    mask_o  = field_mask(size_o);
  end
endmodule

// File: rtl/unary_alu_core.sv
module unary_alu_core
  import unary_alu_pkg::*;
(
  input  kind_e  kind_i,
  input  size_e  size_i,
  input  word_t  mask_i,
  input  word_t  operand_i,
  input  logic   x_i,
  input  logic   z_i,
  output word_t  field_o,
  output flags_t flags_o,
  output logic   borrow_o,
  output logic   ovf_o,
  output logic   zero_o
);
  word_t a_m;
  wide_t diff;
  logic  bin;

  always_comb begin
    a_m  = operand_i & mask_i;
    bin  = (kind_i == KIND_NEGX) ? x_i : 1'b0;
    diff = zero_minus(a_m, bin);

    case (kind_i)
      KIND_NEGX, KIND_NEG: field_o = diff[DATA_W-1:0] & mask_i;
      KIND_NOT:            field_o = ~a_m & mask_i;
      default:             field_o = '0;
    endcase

    borrow_o = diff[DATA_W];
    ovf_o    = field_sign(a_m, size_i) & field_sign(field_o, size_i);
    zero_o   = (field_o == '0);

    flags_o.n = field_sign(field_o, size_i);
    case (kind_i)
      KIND_NEGX: begin
        flags_o.z = z_i & zero_o;
        flags_o.v = ovf_o;
        flags_o.c = borrow_o;
        flags_o.x = borrow_o;
      end
      KIND_NEG: begin
        flags_o.z = zero_o;
        flags_o.v = ovf_o;
        flags_o.c = borrow_o;
        flags_o.x = borrow_o;
      end
      KIND_CLR: begin
        flags_o.n = 1'b0;
        flags_o.z = 1'b1;
        flags_o.v = 1'b0;
        flags_o.c = 1'b0;
        flags_o.x = x_i;
      end
      default: begin
        flags_o.z = zero_o;
        flags_o.v = 1'b0;
        flags_o.c = 1'b0;
        flags_o.x = x_i;
      end
    endcase
  end
endmodule

// File: rtl/unary_alu_cycles.sv
module unary_alu_cycles
  import unary_alu_pkg::*;
#(
  parameter int unsigned CYC_W     = 4,
  parameter int unsigned CYC_SHORT = 4,
  parameter int unsigned CYC_LONG  = 6
) (
  input  size_e            size_i,
  input  logic             legal_i,
  input  logic             mem_i,
  output logic [CYC_W-1:0] cycles_o
);
  localparam logic [CYC_W-1:0] BASE_S = CYC_W'(CYC_SHORT);
  localparam logic [CYC_W-1:0] BASE_L = CYC_W'(CYC_LONG);

  logic [CYC_W-1:0] base;

  always_comb begin
    base = (size_i == SZ_LONG) ? BASE_L : BASE_S;
    if (!legal_i)
      cycles_o = '0;
    else if (mem_i)
      cycles_o = base << 1;
    else
      cycles_o = base;
  end
endmodule

// File: rtl/unary_alu.sv
module unary_alu
  import unary_alu_pkg::*;
#(
  parameter int unsigned CYC_W     = 4,
  parameter int unsigned CYC_SHORT = 4,
  parameter int unsigned CYC_LONG  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op_kind,
  input  logic [1:0]       op_size,
  input  logic [31:0]      operand,
  input  logic             x_in,
  input  logic             z_in,
  input  logic             dst_mem,
  output logic             out_valid,
  output logic [31:0]      result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c,
  output logic             flag_x,
  output logic             illegal,
  output logic [CYC_W-1:0] cycles
);
  size_e            size_w;
  word_t            mask_w;
  logic             legal_w;
  word_t            field_w;
  flags_t           flags_core;
  flags_t           flags_nxt;
  logic             borrow_w;
  logic             ovf_w;
  logic             zero_w;
  logic [CYC_W-1:0] cyc_w;
  word_t            result_nxt;

  unary_alu_size_dec u_size (
    .op_size (op_size),
    .size_o  (size_w),
    .mask_o  (mask_w),
    .legal_o (legal_w)
  );

  unary_alu_core u_core (
    .kind_i    (kind_e'(op_kind)),
    .size_i    (size_w),
    .mask_i    (mask_w),
    .operand_i (operand),
    .x_i       (x_in),
    .z_i       (z_in),
    .field_o   (field_w),
    .flags_o   (flags_core),
    .borrow_o  (borrow_w),
    .ovf_o     (ovf_w),
    .zero_o    (zero_w)
  );

  unary_alu_cycles #(
    .CYC_W     (CYC_W),
    .CYC_SHORT (CYC_SHORT),
    .CYC_LONG  (CYC_LONG)
  ) u_cyc (
    .size_i   (size_w),
    .legal_i  (legal_w),
    .mem_i    (dst_mem),
    .cycles_o (cyc_w)
  );

  always_comb begin
    if (legal_w) begin
      result_nxt = (operand & ~mask_w) | field_w;
      flags_nxt  = flags_core;
    end else begin
      result_nxt  = operand;
      flags_nxt.n = 1'b0;
      flags_nxt.z = z_in;
      flags_nxt.v = 1'b0;
      flags_nxt.c = 1'b0;
      flags_nxt.x = x_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
      flag_x    <= 1'b0;
      illegal   <= 1'b0;
      cycles    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= result_nxt;
        flag_n  <= flags_nxt.n;
        flag_z  <= flags_nxt.z;
        flag_v  <= flags_nxt.v;
        flag_c  <= flags_nxt.c;
        flag_x  <= flags_nxt.x;
        illegal <= ~legal_w;
        cycles  <= cyc_w;
      end
    end
  end
endmodule

// File: rtl/unary_alu_checker.sv
module unary_alu_checker #(
  parameter int unsigned CYC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       op_kind,
  input logic [1:0]       op_size,
  input logic [31:0]      operand,
  input logic             z_in,
  input logic             dst_mem,
  input logic             out_valid,
  input logic [31:0]      result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_v,
  input logic             flag_c,
  input logic             flag_x,
  input logic             illegal,
  input logic [CYC_W-1:0] cycles
);
  logic ok_size;
  assign ok_size = (op_size != 2'd3);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R11
  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ok_size) |=> (illegal && cycles == '0 && result == $past(operand))); // R1
  AST_GOOD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ok_size) |=> !illegal); // R1
  AST_NEGX_Z_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ok_size && op_kind == 2'd0 && !z_in) |=> !flag_z); // R3
  AST_BORROW_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ok_size && !op_kind[0]) |=> (flag_c == flag_x)); // R5
  AST_CLR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ok_size && op_kind == 2'd1) |=> (!flag_n && flag_z && !flag_v && !flag_c)); // R6
  AST_NOT_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ok_size && op_kind == 2'd3) |=> (!flag_v && !flag_c)); // R7
  AST_UPPER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_size == 2'd0) |=> (result[31:8] == $past(operand[31:8]))); // R9
  AST_UPPER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_size == 2'd1) |=> (result[31:16] == $past(operand[31:16]))); // R9
  AST_MEM_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ok_size && dst_mem) |=> (cycles != '0 && !cycles[0])); // R10
endmodule

bind unary_alu unary_alu_checker #(.CYC_W(CYC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_kind   (op_kind),
  .op_size   (op_size),
  .operand   (operand),
  .z_in      (z_in),
  .dst_mem   (dst_mem),
  .out_valid (out_valid),
  .result    (result),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_v    (flag_v),
  .flag_c    (flag_c),
  .flag_x    (flag_x),
  .illegal   (illegal),
  .cycles    (cycles)
);

// File: tb/unary_alu_tb_top.sv
module unary_alu_tb_top;
  localparam int CYC_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [1:0]       op_kind = '0;
  logic [1:0]       op_size = '0;
  logic [31:0]      operand = '0;
  logic             x_in = 1'b0;
  logic             z_in = 1'b0;
  logic             dst_mem = 1'b0;
  logic             out_valid;
  logic [31:0]      result;
  logic             flag_n, flag_z, flag_v, flag_c, flag_x, illegal;
  logic [CYC_W-1:0] cycles;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  unary_alu #(.CYC_W(CYC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
    .op_size(op_size), .operand(operand), .x_in(x_in), .z_in(z_in),
    .dst_mem(dst_mem), .out_valid(out_valid), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .flag_x(flag_x), .illegal(illegal), .cycles(cycles)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] prng(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // Drives one request at a falling edge, checks the registered answer at the next one.
  task automatic run_vec(input logic [1:0] k, input logic [1:0] s, input logic [31:0] a,
                         input logic xi, input logic zi, input logic mi);
    longint w, mask, am, full, r, half, sa, tr, exp_res;
    bit     en, ez, ev, ec, ex;
    int     ecyc;
    string  kt;
    in_valid = 1'b1; op_kind = k; op_size = s; operand = a;
    x_in = xi; z_in = zi; dst_mem = mi;
    kt = (k == 2'd0) ? "R2" : (k == 2'd1) ? "R6" : (k == 2'd2) ? "R4" : "R7";
    if (s == 2'd3) begin
      @(negedge clk);
      chk(illegal == 1'b1, "R1 illegal", longint'(illegal), 1);
      chk(result == a, "R1 result", longint'(result), longint'(a));
      chk({flag_n, flag_v, flag_c} == 3'b000, "R1 nvc", longint'({flag_n, flag_v, flag_c}), 0);
      chk(flag_z == zi && flag_x == xi, "R1 zx", longint'({flag_z, flag_x}), longint'({zi, xi}));
      chk(cycles == '0, "R1 cycles", longint'(cycles), 0);
      return;
    end
    w    = 64'd8 << s;
    mask = (64'd1 << w) - 1;
    half = 64'd1 << (w - 1);
    am   = longint'(a) & mask;
    sa   = (am >= half) ? am - (64'd1 << w) : am;
    case (k)
      2'd0, 2'd2: begin
        full = (0 - am - ((k == 2'd0) ? longint'(xi) : 0)) & ((64'd1 << (w + 1)) - 1);
        r    = full & mask;
        ec   = ((full >> w) & 1) != 0;
        ex   = ec;
        tr   = -sa - ((k == 2'd0) ? longint'(xi) : 0);
        ev   = (tr < -half) || (tr > half - 1);
        ez   = (k == 2'd0) ? (zi && r == 0) : (r == 0);
      end
      2'd1: begin
        r = 0; ec = 0; ev = 0; ez = 1; ex = xi;
      end
      default: begin
        r = (~am) & mask; ec = 0; ev = 0; ez = (r == 0); ex = xi;
      end
    endcase
    en      = (k == 2'd1) ? 1'b0 : (((r >> (w - 1)) & 1) != 0);
    exp_res = (longint'(a) & ~mask & 64'hFFFF_FFFF) | r;
    ecyc    = ((s == 2'd2) ? 6 : 4) * (mi ? 2 : 1);
    @(negedge clk);
    chk(out_valid == 1'b1, "R11 valid", longint'(out_valid), 1);
    chk(illegal == 1'b0, "R1 legal", longint'(illegal), 0);
    chk((longint'(result) & mask) == r, {kt, " field"}, longint'(result) & mask, r);
    chk(longint'(result) == exp_res, "R9 upper", longint'(result), exp_res);
    chk(flag_n == en, "R8 n", longint'(flag_n), longint'(en));
    chk(flag_z == ez, (k == 2'd0) ? "R3 z" : {kt, " z"}, longint'(flag_z), longint'(ez));
    chk(flag_v == ev, k[0] ? {kt, " v"} : "R5 v", longint'(flag_v), longint'(ev));
    chk(flag_c == ec, k[0] ? {kt, " c"} : "R5 c", longint'(flag_c), longint'(ec));
    chk(flag_x == ex, k[0] ? {kt, " x"} : "R5 x", longint'(flag_x), longint'(ex));
    chk(int'(cycles) == ecyc, "R10 cycles", longint'(cycles), longint'(ecyc));
  endtask

  initial begin
    logic [31:0] seed;
    seed = 32'h1357_9BDF;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11 reset valid", longint'(out_valid), 0);
    chk(result == '0 && cycles == '0, "R11 reset data", longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 idle", longint'(out_valid), 0);

    // Exhaustive byte sweep, random upper bits
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 4; k++) begin
        for (int f = 0; f < 8; f++) begin
          seed = prng(seed);
          run_vec(2'(k), 2'd0, {seed[31:8], 8'(a)}, f[0], f[1], f[2]);
        end
      end
    end

    // Word and long: corners then pseudo-random
    for (int s = 1; s < 3; s++) begin
      for (int c = 0; c < 8; c++) begin
        logic [31:0] v;
        case (c)
          0: v = 32'h0;
          1: v = 32'h1;
          2: v = (s == 1) ? 32'hABCD_7FFF : 32'h7FFF_FFFF;
          3: v = (s == 1) ? 32'h1234_8000 : 32'h8000_0000;
          4: v = (s == 1) ? 32'h5A5A_FFFF : 32'hFFFF_FFFF;
          5: v = (s == 1) ? 32'hFFFF_0000 : 32'h0000_8000;
          6: v = 32'h0000_0080;
          default: v = (s == 1) ? 32'h0001_8001 : 32'h8000_0001;
        endcase
        for (int k = 0; k < 4; k++)
          for (int f = 0; f < 8; f++)
            run_vec(2'(k), 2'(s), v, f[0], f[1], f[2]);
      end
      for (int i = 0; i < 1500; i++) begin
        seed = prng(seed);
        run_vec(seed[1:0], 2'(s), prng(seed ^ 32'hC3A5_0F1E), seed[8], seed[9], seed[10]);
      end
    end

    // R1: illegal size code
    for (int i = 0; i < 32; i++) begin
      seed = prng(seed);
      run_vec(seed[1:0], 2'd3, seed, seed[4], seed[5], seed[6]);
    end

    // R11: valid drops one clock after request ends
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 drop", longint'(out_valid), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule